// File: doc/BRIEF.md
# Code Protection Command Filter

This block stands between a flash microcontroller's boot loader, its debug port and the flash array. It decides what each of them may do at the current code-protection level. After power-on reset it fetches one 32-bit protection word from a fixed flash offset through a simple read handshake. It decodes that word into one of four levels and holds the result until the next power-on reset.

From the latched level and a user-code-valid flag captured at the same moment, the block drives three outputs: a debug-port enable, a decision on whether the boot loader enters ISP mode, and a flag that says whether partial flash updates are allowed. Each boot-loader command arrives as an opcode, a start address and a sector range. The command is accepted with a valid/ready handshake. One cycle later the block answers allow or deny, and gives a reason code when it denies.

The filter does no command parsing, and it does not erase or program anything. The surrounding boot loader carries out only the commands that the filter allows.

Top module: `prot_cmd_filter`

## Requirements
- R1: When power-on reset is released, the block holds `fl_rd_req` high with `fl_rd_addr` = 0x2FC until `fl_rd_ack` arrives. On that ack it latches a level decoded from `fl_rd_data` and latches `user_code_ok`. The decoding is 0x12345678 → level 1, 0x87654321 → level 2, 0x43218765 → level 3, and any other value → unprotected.
- R2: Until the level is latched, `dbg_enable`, `isp_enter` and `part_update_ok` are low. Every command is denied with reason 3 (level).
- R3: The latched level and user-code flag change only through `por`. A warm `rst` or a new `fl_rd_data` value leaves them unchanged, and a warm reset issues no new flash read.
- R4: Once latched, `dbg_enable` is high exactly when the level is unprotected.
- R5: `isp_enter` is high when user code is not valid and the level is unprotected, 1 or 2. `part_update_ok` is high when `isp_enter` is high and the level is unprotected or 1.
- R6: A command is taken when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while `por` or `rst` is high. `resp_valid` is high for one cycle in the cycle after acceptance, so back-to-back commands are answered back to back. The opcode encoding is 0 unlock, 1 write-RAM, 2 read-memory, 3 prepare, 4 copy-RAM-to-flash, 5 go, 6 erase and 7 compare. The reason encoding is 0 disabled, 1 address, 2 sector and 3 level. An allowed command reports reason 0.
- R7: At level 3 every command is denied with reason 3.
- R8: At level 1, read-memory and compare are denied with reason 0. A write-RAM whose start address is below 0x10000300 is denied with reason 1. At 0x10000300 or above it is allowed.
- R9: At level 1, a copy-RAM-to-flash whose first target sector is 0 is denied with reason 2. An erase whose range starts at sector 0 is allowed only when it ends at the last sector; otherwise it is denied with reason 2.
- R10: At level 2, write-RAM, read-memory, copy-RAM-to-flash, go and compare are denied with reason 0. An erase is allowed only for the range 0 to SECTORS-1; otherwise it is denied with reason 2. Unlock and prepare are allowed.
- R11: For prepare, copy and erase at levels unprotected, 1 and 2, a range with start greater than end, or with end at or beyond SECTORS, is denied with reason 2. A command disabled at the level reports reason 0 instead.
- R12: At the unprotected level every command with a legal range is allowed, whatever its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; restarts the protection fetch |
| rst | input | 1 | Warm reset, synchronous, active high; clears only the command path |
| fl_rd_req | output | 1 | Flash read request for the protection word |
| fl_rd_addr | output | FL_AW (12) | Flash offset of the protection word |
| fl_rd_data | input | 32 | Flash read data |
| fl_rd_ack | input | 1 | Flash read data valid |
| user_code_ok | input | 1 | User code valid flag, captured with the word |
| dbg_enable | output | 1 | Debug port enable |
| isp_enter | output | 1 | Boot loader enters ISP mode |
| part_update_ok | output | 1 | Partial flash update permitted |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Opcode (see R6) |
| cmd_addr | input | 32 | Start address |
| cmd_lo | input | SEC_W (4) | First sector of range |
| cmd_hi | input | SEC_W (4) | Last sector of range |
| resp_valid | output | 1 | Verdict valid, one cycle |
| resp_allow | output | 1 | Command allowed |
| resp_reason | output | 2 | Deny reason (see R6) |

## Verification
The bench sends a command in the window between reset release and the flash ack. A design that opened the debug port or answered from a default level during that window would grant an allow there. Warm reset is pulsed after the flash word and the user-code flag have changed. A filter that re-sampled the word would then report the unprotected debug enable and allow a read.

Each level is probed at its boundaries. The bench sends a write-RAM one byte below and exactly at the RAM floor, erase ranges that stop one sector short of full coverage, copies into sector 0, inverted and out-of-range sector spans, and disabled commands that also carry bad ranges. Any error in comparison direction, in the last-sector constant or in reason priority shows up as a wrong allow bit or a wrong reason code.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam logic [31:0] KEY_LVL1 = 32'h1234_5678;
    localparam logic [31:0] KEY_LVL2 = 32'h8765_4321;
    localparam logic [31:0] KEY_LVL3 = 32'h4321_8765;

    typedef enum logic [1:0] {
        LV_NONE  = 2'd0,
        LV_ONE   = 2'd1,
        LV_TWO   = 2'd2,
        LV_THREE = 2'd3
    } prot_lvl_e;

    typedef enum logic [2:0] {
        OP_UNLOCK = 3'd0,
        OP_WR_RAM = 3'd1,
        OP_RD_MEM = 3'd2,
        OP_PREP   = 3'd3,
        OP_COPY   = 3'd4,
        OP_GO     = 3'd5,
        OP_ERASE  = 3'd6,
        OP_CMP    = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        RSN_DISABLED = 2'd0,
        RSN_ADDR     = 2'd1,
        RSN_SECTOR   = 2'd2,
        RSN_LEVEL    = 2'd3
    } rsn_e;

    // Captured protection state, frozen once held is set.
    typedef struct packed {
        prot_lvl_e lvl;
        logic      code_ok;
        logic      held;
    } prot_state_t;

    typedef struct packed {
        logic allow;
        rsn_e rsn;
    } verdict_t;

    function automatic prot_lvl_e decode_word(input logic [31:0] w);
        prot_lvl_e l;
        unique case (w)
            KEY_LVL1: l = LV_ONE;
            KEY_LVL2: l = LV_TWO;
            KEY_LVL3: l = LV_THREE;
            default:  l = LV_NONE;
        endcase
        return l;
    endfunction

    function automatic logic op_has_range(input op_e op);
        return (op == OP_PREP) || (op == OP_COPY) || (op == OP_ERASE);
    endfunction

    // Commands switched off outright at a given level.
    function automatic logic op_blocked(input prot_lvl_e l, input op_e op);
        logic b;
        b = 1'b0;
        case (l)
            LV_ONE:   b = (op == OP_RD_MEM) || (op == OP_CMP);
            LV_TWO:   b = (op == OP_WR_RAM) || (op == OP_RD_MEM) || (op == OP_COPY)
                       || (op == OP_GO)     || (op == OP_CMP);
            LV_THREE: b = 1'b1;
            default:  b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/prot_word_sampler.sv
module prot_word_sampler
    import prot_pkg::*;
#(
    parameter int          FL_AW    = 12,
    parameter int unsigned PROT_OFS = 32'h2FC
) (
    input  logic              clk,
    input  logic              por,
    output logic              fl_rd_req,
    output logic [FL_AW-1:0]  fl_rd_addr,
    input  logic [31:0]       fl_rd_data,
    input  logic              fl_rd_ack,
    input  logic              user_code_ok,
    output prot_state_t       st
);

    typedef enum logic {SM_FETCH, SM_HELD} smp_e;
    smp_e sm;

    assign fl_rd_req  = (sm == SM_FETCH) && !por;
    assign fl_rd_addr = FL_AW'(PROT_OFS);

    // Only power-on reset touches this state.
    always_ff @(posedge clk) begin
        if (por) begin
            sm <= SM_FETCH;
            st <= '{lvl: LV_NONE, code_ok: 1'b0, held: 1'b0};
        end else if (sm == SM_FETCH && fl_rd_ack) begin
            sm         <= SM_HELD;
            st.lvl     <= decode_word(fl_rd_data);
            st.code_ok <= user_code_ok;
            st.held    <= 1'b1;
        end
    end

    // R3: once held, level and flag never move until the next power-on.
    assert_level_frozen_R3: assert property (@(posedge clk) disable iff (por)
        (st.held && $past(st.held)) |-> ($stable(st.lvl) && $stable(st.code_ok)));

    // R1: the state becomes valid only on an acknowledged read.
    assert_latch_on_ack_R1: assert property (@(posedge clk) disable iff (por)
        $rose(st.held) |-> $past(fl_rd_ack && fl_rd_req));

endmodule

// File: rtl/prot_policy_map.sv
module prot_policy_map
    import prot_pkg::*;
(
    input  prot_state_t st,
    output logic        dbg_enable,
    output logic        isp_enter,
    output logic        part_update_ok
);

    logic boot_lvl;
    logic partial_lvl;

    always_comb begin
        boot_lvl    = 1'b0;
        partial_lvl = 1'b0;
        case (st.lvl)
            LV_NONE: begin boot_lvl = 1'b1; partial_lvl = 1'b1; end
            LV_ONE:  begin boot_lvl = 1'b1; partial_lvl = 1'b1; end
            LV_TWO:  begin boot_lvl = 1'b1; partial_lvl = 1'b0; end
            default: begin boot_lvl = 1'b0; partial_lvl = 1'b0; end
        endcase
        dbg_enable     = st.held && (st.lvl == LV_NONE);
        isp_enter      = st.held && !st.code_ok && boot_lvl;
        part_update_ok = isp_enter && partial_lvl;
    end

endmodule

// File: rtl/prot_cmd_rules.sv
module prot_cmd_rules
    import prot_pkg::*;
#(
    parameter int          SECTORS   = 8,
    parameter int          ADDR_W    = 32,
    parameter int unsigned RAM_FLOOR = 32'h1000_0300,
    localparam int         SEC_W     = $clog2(SECTORS) + 1
) (
    input  logic              clk,
    input  logic              rst_any,
    input  prot_state_t       st,
    input  logic              cmd_fire,
    input  op_e               cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [SEC_W-1:0]  cmd_lo,
    input  logic [SEC_W-1:0]  cmd_hi,
    output logic              resp_valid,
    output logic              resp_allow,
    output logic [1:0]        resp_reason
);

    localparam logic [SEC_W-1:0]  LAST_SEC = SEC_W'(SECTORS - 1);
    localparam logic [ADDR_W-1:0] FLOOR    = ADDR_W'(RAM_FLOOR);

    logic     range_bad;
    logic     full_span;
    logic     hits_sec0;
    verdict_t v;
    verdict_t v_q;

    assign range_bad = (cmd_lo > cmd_hi) || (cmd_hi > LAST_SEC);
    assign hits_sec0 = (cmd_lo == '0);
    assign full_span = hits_sec0 && (cmd_hi == LAST_SEC);

    // Fixed priority: level, disabled, bad range, level-specific rules.
    always_comb begin
        v = '{allow: 1'b1, rsn: RSN_DISABLED};
        if (!st.held || st.lvl == LV_THREE) begin
            v = '{allow: 1'b0, rsn: RSN_LEVEL};
        end else if (op_blocked(st.lvl, cmd_op)) begin
            v = '{allow: 1'b0, rsn: RSN_DISABLED};
        end else if (op_has_range(cmd_op) && range_bad) begin
            v = '{allow: 1'b0, rsn: RSN_SECTOR};
        end else begin
            case (st.lvl)
                LV_ONE: begin
                    if (cmd_op == OP_WR_RAM && cmd_addr < FLOOR)
                        v = '{allow: 1'b0, rsn: RSN_ADDR};
                    else if (cmd_op == OP_COPY && hits_sec0)
                        v = '{allow: 1'b0, rsn: RSN_SECTOR};
                    else if (cmd_op == OP_ERASE && hits_sec0 && !full_span)
                        v = '{allow: 1'b0, rsn: RSN_SECTOR};
                end
                LV_TWO: begin
                    if (cmd_op == OP_ERASE && !full_span)
                        v = '{allow: 1'b0, rsn: RSN_SECTOR};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst_any) begin
            resp_valid <= 1'b0;
            v_q        <= '{allow: 1'b0, rsn: RSN_LEVEL};
        end else begin
            resp_valid <= cmd_fire;
            if (cmd_fire) v_q <= v;
        end
    end

    assign resp_allow  = v_q.allow;
    assign resp_reason = v_q.rsn;

    // R10: a granted erase at level 2 covered every sector.
    assert_l2_erase_span_R10: assert property (@(posedge clk) disable iff (rst_any)
        (resp_valid && resp_allow && st.lvl == LV_TWO && $past(cmd_op) == OP_ERASE)
        |-> ($past(cmd_lo) == '0 && $past(cmd_hi) == LAST_SEC));

    // R8: a granted RAM write at level 1 started at or above the floor.
    assert_l1_ram_floor_R8: assert property (@(posedge clk) disable iff (rst_any)
        (resp_valid && resp_allow && st.lvl == LV_ONE && $past(cmd_op) == OP_WR_RAM)
        |-> ($past(cmd_addr) >= FLOOR));

endmodule

// File: rtl/prot_cmd_filter.sv
module prot_cmd_filter
    import prot_pkg::*;
#(
    parameter int          SECTORS   = 8,
    parameter int          FL_AW     = 12,
    parameter int unsigned PROT_OFS  = 32'h2FC,
    parameter int unsigned RAM_FLOOR = 32'h1000_0300,
    localparam int         SEC_W     = $clog2(SECTORS) + 1
) (
    input  logic             clk,
    input  logic             por,
    input  logic             rst,
    output logic             fl_rd_req,
    output logic [FL_AW-1:0] fl_rd_addr,
    input  logic [31:0]      fl_rd_data,
    input  logic             fl_rd_ack,
    input  logic             user_code_ok,
    output logic             dbg_enable,
    output logic             isp_enter,
    output logic             part_update_ok,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [31:0]      cmd_addr,
    input  logic [SEC_W-1:0] cmd_lo,
    input  logic [SEC_W-1:0] cmd_hi,
    output logic             resp_valid,
    output logic             resp_allow,
    output logic [1:0]       resp_reason
);

    prot_state_t st;
    logic        rst_any;
    logic        cmd_fire;

    assign rst_any   = por | rst;
    assign cmd_ready = !rst_any;
    assign cmd_fire  = cmd_valid && cmd_ready;

    prot_word_sampler #(
        .FL_AW    (FL_AW),
        .PROT_OFS (PROT_OFS)
    ) u_sampler (
        .clk          (clk),
        .por          (por),
        .fl_rd_req    (fl_rd_req),
        .fl_rd_addr   (fl_rd_addr),
        .fl_rd_data   (fl_rd_data),
        .fl_rd_ack    (fl_rd_ack),
        .user_code_ok (user_code_ok),
        .st           (st)
    );

    prot_policy_map u_policy (
        .st             (st),
        .dbg_enable     (dbg_enable),
        .isp_enter      (isp_enter),
        .part_update_ok (part_update_ok)
    );

    prot_cmd_rules #(
        .SECTORS   (SECTORS),
        .ADDR_W    (32),
        .RAM_FLOOR (RAM_FLOOR)
    ) u_rules (
        .clk         (clk),
        .rst_any     (rst_any),
        .st          (st),
        .cmd_fire    (cmd_fire),
        .cmd_op      (op_e'(cmd_op)),
        .cmd_addr    (cmd_addr),
        .cmd_lo      (cmd_lo),
        .cmd_hi      (cmd_hi),
        .resp_valid  (resp_valid),
        .resp_allow  (resp_allow),
        .resp_reason (resp_reason)
    );

    // R6: every verdict answers a command taken one cycle earlier.
    assert_resp_follows_cmd_R6: assert property (@(posedge clk) disable iff (rst_any)
        resp_valid |-> $past(cmd_valid && cmd_ready));

    // R7 / R2: no grant at level 3 or before the word was captured.
    assert_no_grant_locked_R7: assert property (@(posedge clk) disable iff (rst_any)
        (resp_valid && resp_allow) |-> ($past(st.held) && st.lvl != LV_THREE));

    // R4: the debug port never opens while a protected level is held.
    assert_dbg_closed_R4: assert property (@(posedge clk) disable iff (por)
        (st.held && st.lvl != LV_NONE) |-> !dbg_enable);

endmodule

// File: tb/test_prot_cmd_filter.sv
`timescale 1ns/1ps
module test_prot_cmd_filter;

    localparam int SECTORS = 8;
    localparam int SEC_W   = $clog2(SECTORS) + 1;
    localparam int FL_AW   = 12;

    localparam logic [2:0] C_UNLOCK = 3'd0, C_WRRAM = 3'd1, C_RDMEM = 3'd2, C_PREP = 3'd3,
                           C_COPY = 3'd4, C_GO = 3'd5, C_ERASE = 3'd6, C_CMP = 3'd7;

    logic             clk = 1'b0;
    logic             por = 1'b1;
    logic             rst = 1'b0;
    logic             fl_rd_req;
    logic [FL_AW-1:0] fl_rd_addr;
    logic [31:0]      fl_rd_data;
    logic             fl_rd_ack = 1'b0;
    logic             user_code_ok = 1'b0;
    logic             dbg_enable, isp_enter, part_update_ok;
    logic             cmd_valid = 1'b0;
    logic             cmd_ready;
    logic [2:0]       cmd_op = '0;
    logic [31:0]      cmd_addr = '0;
    logic [SEC_W-1:0] cmd_lo = '0, cmd_hi = '0;
    logic             resp_valid, resp_allow;
    logic [1:0]       resp_reason;

    always #4 clk = ~clk;

    prot_cmd_filter #(.SECTORS(SECTORS)) i_prot_cmd_filter (
        .clk(clk), .por(por), .rst(rst),
        .fl_rd_req(fl_rd_req), .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data),
        .fl_rd_ack(fl_rd_ack), .user_code_ok(user_code_ok),
        .dbg_enable(dbg_enable), .isp_enter(isp_enter), .part_update_ok(part_update_ok),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
        .resp_valid(resp_valid), .resp_allow(resp_allow), .resp_reason(resp_reason)
    );

    int checks = 0;
    int errors = 0;

    // Flash model: answers only a read of the protection offset.
    logic [31:0] flash_word = 32'hFFFF_FFFF;
    logic        ack_en = 1'b0;
    assign fl_rd_data = flash_word;
    always @(negedge clk) fl_rd_ack = ack_en && fl_rd_req && (fl_rd_addr == 12'h2FC);

    // Reference state the bench believes the block holds.
    int m_lvl  = 0;
    bit m_held = 1'b0;

    typedef struct {
        logic       allow;
        logic [1:0] rsn;
        int         req;
        logic [2:0] op;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input logic [2:0] op, input logic [31:0] addr,
                                         input int lo, input int hi);
        bit rng  = (op == C_PREP) || (op == C_COPY) || (op == C_ERASE);
        bit bad  = (lo > hi) || (hi >= SECTORS);
        bit full = (lo == 0) && (hi == SECTORS - 1);
        if (!m_held || m_lvl == 3) return {1'b0, 2'd3};
        if (m_lvl == 1 && (op == C_RDMEM || op == C_CMP)) return {1'b0, 2'd0};
        if (m_lvl == 2 && (op == C_WRRAM || op == C_RDMEM || op == C_COPY ||
                           op == C_GO || op == C_CMP)) return {1'b0, 2'd0};
        if (rng && bad) return {1'b0, 2'd2};
        if (m_lvl == 1) begin
            if (op == C_WRRAM && addr < 32'h1000_0300) return {1'b0, 2'd1};
            if (op == C_COPY && lo == 0) return {1'b0, 2'd2};
            if (op == C_ERASE && lo == 0 && !full) return {1'b0, 2'd2};
        end
        if (m_lvl == 2 && op == C_ERASE && !full) return {1'b0, 2'd2};
        return {1'b1, 2'd0};
    endfunction

    // Driver: called at a falling edge, presents one command for one cycle.
    task automatic send(input logic [2:0] op, input logic [31:0] addr,
                        input int lo, input int hi, input int req);
        logic [2:0] e;
        exp_t it;
        e = model(op, addr, lo, hi);
        it.allow = e[2]; it.rsn = e[1:0]; it.req = req; it.op = op;
        sbq.push_back(it);
        cmd_op = op; cmd_addr = addr;
        cmd_lo = SEC_W'(lo); cmd_hi = SEC_W'(hi);
        cmd_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic drain();
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, 6, "responses outstanding", sbq.size(), 0);
    endtask

    // Monitor: compares each verdict with the oldest expectation.
    always @(negedge clk) begin
        if (resp_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, 6, "unexpected resp_valid", 1, 0);
            end else begin
                exp_t it;
                it = sbq.pop_front();
                chk(resp_allow == it.allow && resp_reason == it.rsn, it.req,
                    $sformatf("verdict op %0d {allow,reason}", it.op),
                    {29'd0, resp_allow, resp_reason}, {29'd0, it.allow, it.rsn});
            end
        end
    end

    task automatic powerup(input logic [31:0] word, input bit ucv, input int lvl);
        flash_word = word; user_code_ok = ucv; ack_en = 1'b0; m_held = 1'b0;
        cmd_valid = 1'b0; por = 1'b1;
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b0, 6, "cmd_ready during por", cmd_ready, 0);   // R6
        por = 1'b0;
        repeat (2) @(negedge clk);
        chk(fl_rd_req == 1'b1, 1, "fl_rd_req after por", fl_rd_req, 1);    // R1
        chk(fl_rd_addr == 12'h2FC, 1, "fl_rd_addr", fl_rd_addr, 32'h2FC);   // R1
        chk(dbg_enable == 1'b0, 2, "dbg before latch", dbg_enable, 0);      // R2
        chk(isp_enter == 1'b0, 2, "isp before latch", isp_enter, 0);        // R2
        send(C_UNLOCK, 0, 0, 0, 2);                                         // R2
        send(C_ERASE, 0, 0, SECTORS - 1, 2);                                // R2
        drain();
        ack_en = 1'b1;
        repeat (3) @(negedge clk);
        m_held = 1'b1; m_lvl = lvl;
        chk(fl_rd_req == 1'b0, 1, "fl_rd_req after ack", fl_rd_req, 0);    // R1
        chk(dbg_enable == (lvl == 0), 4, "dbg_enable", dbg_enable, (lvl == 0)); // R4
        chk(isp_enter == (!ucv && lvl != 3), 5, "isp_enter", isp_enter,
            (!ucv && lvl != 3));                                            // R5
        chk(part_update_ok == (!ucv && lvl <= 1), 5, "part_update_ok", part_update_ok,
            (!ucv && lvl <= 1));                                            // R5
    endtask

    task automatic sweep_ops(input int req);
        for (int op = 0; op < 8; op++) send(3'(op), 32'h1000_0400, 2, 5, req);
        drain();
    endtask

    initial begin
        // Unprotected, user code valid: everything with a legal range passes (R12).
        powerup(32'hFFFF_FFFF, 1'b1, 0);
        sweep_ops(12);                                      // R12
        send(C_WRRAM, 32'h0000_0000, 0, 0, 12);             // R12 low address fine
        send(C_ERASE, 0, 5, 3, 11);                         // R11 inverted range
        send(C_ERASE, 0, 0, SECTORS, 11);                   // R11 end past last sector
        send(C_PREP, 0, 7, 7, 11);                          // R11 single sector ok
        drain();

        // Unprotected, user code invalid (R5).
        powerup(32'h1234_5679, 1'b0, 0);

        // Level 1, user code invalid.
        powerup(32'h1234_5678, 1'b0, 1);
        send(C_RDMEM, 32'h1000_0400, 0, 0, 8);              // R8
        send(C_CMP, 32'h1000_0400, 0, 0, 8);                // R8
        send(C_WRRAM, 32'h1000_02FF, 0, 0, 8);              // R8 one below floor
        send(C_WRRAM, 32'h1000_0300, 0, 0, 8);              // R8 at floor
        send(C_COPY, 0, 0, 2, 9);                           // R9 sector 0 target
        send(C_COPY, 0, 1, 2, 9);                           // R9
        send(C_ERASE, 0, 0, SECTORS - 2, 9);                // R9 one short
        send(C_ERASE, 0, 0, SECTORS - 1, 9);                // R9 all sectors
        send(C_ERASE, 0, 2, 5, 9);                          // R9 partial w/o sector 0
        send(C_GO, 0, 0, 0, 9);
        send(C_PREP, 0, 6, 3, 11);                          // R11
        send(C_CMP, 0, 6, 3, 11);                           // R11 disabled wins
        drain();

        // Warm reset with new flash contents keeps level 1 (R3).
        flash_word = 32'h0000_0000; user_code_ok = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b0, 6, "cmd_ready during rst", cmd_ready, 0); // R6
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(fl_rd_req == 1'b0, 3, "no refetch on warm reset", fl_rd_req, 0); // R3
        chk(dbg_enable == 1'b0, 3, "dbg after warm reset", dbg_enable, 0);    // R3
        chk(isp_enter == 1'b1, 3, "isp after warm reset", isp_enter, 1);      // R3
        send(C_RDMEM, 0, 0, 0, 3);                                            // R3
        drain();

        // Level 2 (R10).
        powerup(32'h8765_4321, 1'b0, 2);
        sweep_ops(10);                                      // R10
        send(C_ERASE, 0, 0, SECTORS - 1, 10);
        send(C_ERASE, 0, 1, SECTORS - 1, 10);
        send(C_PREP, 0, 0, SECTORS - 1, 10);
        send(C_COPY, 0, 4, 1, 11);                          // R11 disabled wins
        drain();

        // Level 3, both user-code states (R7).
        powerup(32'h4321_8765, 1'b0, 3);
        sweep_ops(7);                                       // R7
        powerup(32'h4321_8765, 1'b1, 3);
        send(C_ERASE, 0, 0, SECTORS - 1, 7);                // R7
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL R6 watchdog expired actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule